// File: doc/BRIEF.md
# Shared Work-RAM Bank Mapper

This block decides which physical 32 KB bank of shared work RAM serves a request from one of three requester classes: the main CPU, the application CPU and the DSP. It keeps sixteen control bytes, one per physical bank. The first eight describe code banks and the last eight describe data banks. Each byte names the requester that owns the bank, the 32 KB slot that the bank fills within that requester's window, and whether the bank is enabled.

Because ownership and slot position belong to each bank rather than to each address, a lookup is a reverse search. The block compares the requested slot against every bank of the selected type and reports the bank that claims it. A byte-wide register port writes and reads the control bytes. A lookup port takes a requester ID, a code/data select and a slot number. One clock later it returns a valid strobe, a hit flag, the winning bank index and a flag that marks contention between banks.

Top module: `wram_bank_mapper`

## Requirements
- R1: After reset every control byte reads back as 0x00, and every lookup misses.
- R2: A write at register address A (0 to 7 for code banks 0 to 7, 8 to 15 for data banks 0 to 7) stores bits 7 and 4:0 of the byte. A read at the same address returns them with bits 6:5 always zero, so writing 0xFF reads back as 0x9F. The read is combinational in the address.
- R3: A bank whose enable bit 7 is 0 never produces a hit, whatever its other fields hold.
- R4: The owner field in bits 1:0 matches requester ID 0 (main CPU) only when it is 0, and requester ID 1 (application CPU) only when it is 1. The DSP may present requester ID 2 or 3, and either ID matches owner values 2 and 3.
- R5: A code lookup (select 0) considers only register addresses 0 to 7, and a data lookup (select 1) considers only addresses 8 to 15. The returned bank index equals the register address of the winning bank.
- R6: A bank matches only when its slot field in bits 4:2 equals the requested slot.
- R7: When several banks match one lookup, the one with the lowest register address is returned and the conflict flag is raised. A single match leaves the conflict flag low.
- R8: A lookup with no matching bank returns hit 0, bank index 0 and conflict 0.
- R9: The outputs are registered. The valid strobe is high in the cycle after a request was presented and low otherwise. When valid is low, hit, conflict and bank index are zero. A lookup uses the control bytes as they stood in the cycle of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe for the control byte at reg_addr |
| reg_addr | input | 4 | Control byte address (code banks first) |
| reg_wdata | input | 8 | Byte to write |
| reg_rdata | output | 8 | Control byte at reg_addr, bits 6:5 zero |
| lkp_req | input | 1 | Lookup request |
| lkp_src | input | 2 | Requester ID: 0 main CPU, 1 application CPU, 2 or 3 DSP |
| lkp_is_data | input | 1 | 0 selects code banks, 1 selects data banks |
| lkp_slot | input | 3 | Requested slot within the requester's window |
| lkp_valid | output | 1 | Registered result strobe |
| lkp_hit | output | 1 | A bank serves the lookup |
| lkp_bank | output | 4 | Winning bank index (register address) |
| lkp_conflict | output | 1 | More than one bank matched |

## Verification
The hardest case to reach is contention. To create it, software must program two enabled banks of the same type with the same owner class and the same slot, and a good bench also covers the case where the two owner values differ but both denote the DSP. The stimulus first programs a fixed bank map that holds such pairs in both the code group and the data group. It also places disabled and owner-mismatched decoys next to the live entries. A vector table of lookups is then run against that map. Directed steps follow: they disable a bank, move a bank to another slot, and confirm that the 0xFF write loses its unused bits.

// File: rtl/wram_map_pkg.sv
package wram_map_pkg;

    // Owner encoding held in bits 1:0 of a control byte
    typedef enum logic [1:0] {
        OWN_MAIN    = 2'd0,
        OWN_APP     = 2'd1,
        OWN_DSP     = 2'd2,
        OWN_DSP_ALT = 2'd3
    } owner_e;

    // Stored part of one control byte (bits 6:5 are not kept)
    typedef struct packed {
        logic       en;
        logic [2:0] slot;
        owner_e     owner;
    } bank_ctrl_t;

    // Both DSP encodings are one requester class
    function automatic logic owner_matches(owner_e owner, logic [1:0] src);
        if (owner[1]) return src[1];
        return (src == logic'(owner) ? 1'b1 : 1'b0) && !src[1] && (src[0] == owner[0]);
    endfunction

    function automatic logic [7:0] pack_ctrl(bank_ctrl_t c);
        return {c.en, 2'b00, c.slot, logic'(c.owner[1]), logic'(c.owner[0])};
    endfunction

endpackage

// File: rtl/wram_bank_regs.sv
module wram_bank_regs
    import wram_map_pkg::*;
#(
    parameter int NBANK = 16,
    localparam int AW   = $clog2(NBANK)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [AW-1:0]          addr,
    input  logic [7:0]             wdata,
    output logic [7:0]             rdata,
    output bank_ctrl_t [NBANK-1:0] ctrl
);

    bank_ctrl_t [NBANK-1:0] bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (we && (int'(addr) < NBANK)) begin
            bank_d[addr].en    = wdata[7];
            bank_d[addr].slot  = wdata[4:2];
            bank_d[addr].owner = owner_e'(wdata[1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    always_comb begin
        rdata = 8'h00;
        if (int'(addr) < NBANK) rdata = pack_ctrl(bank_q[addr]);
    end

    assign ctrl = bank_q;

endmodule

// File: rtl/wram_bank_lookup.sv
module wram_bank_lookup
    import wram_map_pkg::*;
#(
    parameter int PER_TYPE = 8,
    localparam int NBANK   = 2 * PER_TYPE,
    localparam int BW      = $clog2(NBANK),
    localparam int IW      = (PER_TYPE > 1) ? $clog2(PER_TYPE) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  bank_ctrl_t [NBANK-1:0] ctrl,
    input  logic                   req,
    input  logic [1:0]             src,
    input  logic                   is_data,
    input  logic [2:0]             slot,
    output logic                   valid,
    output logic                   hit,
    output logic                   conflict,
    output logic [BW-1:0]          bank
);

    typedef struct packed {
        logic          valid;
        logic          hit;
        logic          conflict;
        logic [BW-1:0] bank;
    } res_t;

    res_t                res_d, res_q;
    logic [PER_TYPE-1:0] match;
    logic [IW-1:0]       win;

    // One comparator per bank position within the selected type
    for (genvar g = 0; g < PER_TYPE; g++) begin : g_match
        bank_ctrl_t sel;
        assign sel = is_data ? ctrl[PER_TYPE + g] : ctrl[g];
        assign match[g] = sel.en && (sel.slot == slot) && owner_matches(sel.owner, src);
    end

    always_comb begin
        // Lowest index wins: scan from the top so the last hit kept is the lowest
        win = '0;
        for (int i = PER_TYPE - 1; i >= 0; i--) begin
            if (match[i]) win = IW'(i);
        end

        res_d          = '0;
        res_d.valid    = req;
        res_d.hit      = req && (|match);
        res_d.conflict = res_d.hit && (|(match & (match - 1'b1)));
        if (res_d.hit)
            res_d.bank = is_data ? BW'(PER_TYPE + int'(win)) : BW'(int'(win));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign valid    = res_q.valid;
    assign hit      = res_q.hit;
    assign conflict = res_q.conflict;
    assign bank     = res_q.bank;

endmodule

// File: rtl/wram_bank_mapper.sv
module wram_bank_mapper
    import wram_map_pkg::*;
#(
    parameter int  BANKS_PER_TYPE = 8,
    localparam int BANK_IDX_W     = $clog2(2 * BANKS_PER_TYPE)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [BANK_IDX_W-1:0] reg_addr,
    input  logic [7:0]            reg_wdata,
    output logic [7:0]            reg_rdata,
    input  logic                  lkp_req,
    input  logic [1:0]            lkp_src,
    input  logic                  lkp_is_data,
    input  logic [2:0]            lkp_slot,
    output logic                  lkp_valid,
    output logic                  lkp_hit,
    output logic [BANK_IDX_W-1:0] lkp_bank,
    output logic                  lkp_conflict
);

    localparam int NBANK = 2 * BANKS_PER_TYPE;

    bank_ctrl_t [NBANK-1:0] ctrl;

    wram_bank_regs #(.NBANK(NBANK)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .ctrl  (ctrl)
    );

    wram_bank_lookup #(.PER_TYPE(BANKS_PER_TYPE)) u_lookup (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl     (ctrl),
        .req      (lkp_req),
        .src      (lkp_src),
        .is_data  (lkp_is_data),
        .slot     (lkp_slot),
        .valid    (lkp_valid),
        .hit      (lkp_hit),
        .conflict (lkp_conflict),
        .bank     (lkp_bank)
    );

endmodule

// File: rtl/wram_bank_mapper_chk.sv
module wram_bank_mapper_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       reg_rdata,
    input logic             lkp_req,
    input logic             lkp_is_data,
    input logic             lkp_valid,
    input logic             lkp_hit,
    input logic [IDX_W-1:0] lkp_bank,
    input logic             lkp_conflict
);

    // R9
    req_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_req |=> lkp_valid);

    // R9
    idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lkp_req |=> (!lkp_valid && !lkp_hit && !lkp_conflict && lkp_bank == '0));

    // R8
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lkp_hit |-> (lkp_bank == '0 && !lkp_conflict));

    // R7
    conflict_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_conflict |-> (lkp_hit && lkp_valid));

    // R5
    bank_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_req ##1 lkp_hit) |-> (lkp_bank[IDX_W-1] == $past(lkp_is_data)));

    // R2
    unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[6:5] == 2'b00);

endmodule

bind wram_bank_mapper wram_bank_mapper_chk #(.IDX_W(BANK_IDX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_rdata    (reg_rdata),
    .lkp_req      (lkp_req),
    .lkp_is_data  (lkp_is_data),
    .lkp_valid    (lkp_valid),
    .lkp_hit      (lkp_hit),
    .lkp_bank     (lkp_bank),
    .lkp_conflict (lkp_conflict)
);

// File: tb/wram_bank_mapper_tb.sv
`timescale 1ns/1ps
module wram_bank_mapper_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       lkp_req = 1'b0;
    logic [1:0] lkp_src = '0;
    logic       lkp_is_data = 1'b0;
    logic [2:0] lkp_slot = '0;
    logic       lkp_valid, lkp_hit, lkp_conflict;
    logic [3:0] lkp_bank;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    wram_bank_mapper u_dut (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lkp_req(lkp_req), .lkp_src(lkp_src), .lkp_is_data(lkp_is_data), .lkp_slot(lkp_slot),
        .lkp_valid(lkp_valid), .lkp_hit(lkp_hit), .lkp_bank(lkp_bank), .lkp_conflict(lkp_conflict)
    );

    typedef struct packed {
        logic [1:0] src;
        logic       d;
        logic [2:0] slot;
        logic       hit;
        logic [3:0] bank;
        logic       conf;
    } vec_t;

    // Expected results for the bank map programmed below
    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 3'd3, 1'b1, 4'd0,  1'b0},  // R4 main owns code 0
        '{2'd1, 1'b0, 3'd3, 1'b1, 4'd1,  1'b1},  // R7 banks 1 and 5
        '{2'd2, 1'b0, 3'd5, 1'b1, 4'd2,  1'b0},  // R4 DSP id 2, owner 2
        '{2'd3, 1'b0, 3'd6, 1'b1, 4'd3,  1'b0},  // R4 DSP id 3, owner 3
        '{2'd2, 1'b0, 3'd6, 1'b1, 4'd3,  1'b0},  // R4 DSP id 2, owner 3
        '{2'd0, 1'b0, 3'd1, 1'b0, 4'd0,  1'b0},  // R3 bank 4 disabled
        '{2'd0, 1'b0, 3'd7, 1'b1, 4'd6,  1'b0},  // R6
        '{2'd1, 1'b0, 3'd5, 1'b0, 4'd0,  1'b0},  // R4 owner mismatch
        '{2'd0, 1'b1, 3'd3, 1'b1, 4'd8,  1'b0},  // R5 data group
        '{2'd2, 1'b1, 3'd0, 1'b1, 4'd9,  1'b1},  // R7 owners 2 and 3 collide
        '{2'd2, 1'b1, 3'd7, 1'b1, 4'd11, 1'b0},  // R2 0xFF write used as DSP slot 7
        '{2'd0, 1'b1, 3'd7, 1'b0, 4'd0,  1'b0},  // R8 miss
        '{2'd0, 1'b0, 3'd2, 1'b0, 4'd0,  1'b0},  // R6 R8 no slot
        '{2'd1, 1'b1, 3'd3, 1'b0, 4'd0,  1'b0}   // R5 code bank 1 not seen by data
    };

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [3:0] a, logic [7:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp, $sformatf("readback addr %0d", a));
    endtask

    // Present a request for one cycle, sample the registered result
    task automatic look(string req, logic [1:0] s, logic d, logic [2:0] sl,
                        logic eh, logic [3:0] eb, logic ec);
        @(negedge clk);
        lkp_req = 1'b1; lkp_src = s; lkp_is_data = d; lkp_slot = sl;
        @(negedge clk);
        lkp_req = 1'b0;
        chk(req, {7'd0, lkp_valid}, 8'd1, "valid");
        chk(req, {7'd0, lkp_hit}, {7'd0, eh}, "hit");
        chk(req, {4'd0, lkp_bank}, {4'd0, eb}, "bank");
        chk(req, {7'd0, lkp_conflict}, {7'd0, ec}, "conflict");
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 16; a++) rd_chk("R1", 4'(a), 8'h00);
        look("R1", 2'd0, 1'b0, 3'd0, 1'b0, 4'd0, 1'b0);

        // Program the bank map
        wr(4'd0, 8'h8C); wr(4'd1, 8'h8D); wr(4'd2, 8'h96); wr(4'd3, 8'h9B);
        wr(4'd4, 8'h04); wr(4'd5, 8'h8D); wr(4'd6, 8'h9C);
        wr(4'd8, 8'h8C); wr(4'd9, 8'h82); wr(4'd10, 8'h83); wr(4'd11, 8'hFF);

        // R2 readback, unused bits cleared
        rd_chk("R2", 4'd11, 8'h9F);
        rd_chk("R2", 4'd2, 8'h96);
        rd_chk("R2", 4'd7, 8'h00);

        for (int i = 0; i < NV; i++)
            look($sformatf("vector %0d", i), VECS[i].src, VECS[i].d, VECS[i].slot,
                 VECS[i].hit, VECS[i].bank, VECS[i].conf);

        // R9 valid drops after the request goes away
        @(negedge clk);
        chk("R9", {5'd0, lkp_valid, lkp_hit, lkp_conflict}, 8'd0, "idle outputs");
        chk("R9", {4'd0, lkp_bank}, 8'd0, "idle bank");

        // R3 disabling bank 0 removes its hit
        wr(4'd0, 8'h0C);
        look("R3", 2'd0, 1'b0, 3'd3, 1'b0, 4'd0, 1'b0);

        // R6 moving bank 0 to slot 4
        wr(4'd0, 8'h90);
        look("R6", 2'd0, 1'b0, 3'd4, 1'b1, 4'd0, 1'b0);
        look("R6", 2'd0, 1'b0, 3'd3, 1'b0, 4'd0, 1'b0);

        // R7 lowest index wins when bank 5 is removed and bank 7 joins
        wr(4'd5, 8'h00); wr(4'd7, 8'h8D);
        look("R7", 2'd1, 1'b0, 3'd3, 1'b1, 4'd1, 1'b1);
        wr(4'd1, 8'h00);
        look("R7", 2'd1, 1'b0, 3'd3, 1'b1, 4'd7, 1'b0);

        // R1 reset clears everything again
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd_chk("R1", 4'd11, 8'h00);
        look("R1", 2'd2, 1'b1, 3'd7, 1'b0, 4'd0, 1'b0);

        finish_run();
    end

endmodule